// File: doc/BRIEF.md
# Four-Channel DMA Address Sequencer

This block generates the addresses and picks the channel for a four-channel DMA engine. Each transfer reads from a source and then writes to a destination. Every channel holds its own source and destination pointers, a remaining byte count, a unit size and a step mode for each pointer. A channel can also run in one of two reload modes. In circular mode both pointers return to their row start after a programmed number of bytes. In two-dimensional mode a pitch is added to both row starts at that boundary.

A channel is triggered by its external request line or by a software start. A software start stays pending until the channel finishes, and it is refused while the channel is in circular mode. An arbiter chooses the next channel to serve, using either fixed priority or round-robin. The chosen channel moves one unit: every read beat of the unit completes into that channel's 32-byte buffer before the buffer is written out. After the unit, the shared update logic advances the pointers and the counts.

Configuration arrives through a single-word write port that selects a channel and a field. The memory side is a word-wide request/acknowledge interface. The request, address and direction stay steady until the acknowledge arrives.

Top module: `dmaAddrSequencer`

## Requirements
- R1: For each unit, all read beats take place before any write beat, and each written word equals the word read at the matching beat. After idle, a memory request always starts as a read.
- R2: The unit size code in control bits [2:1] selects the unit length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 32 bytes. A 32-byte unit is eight word beats at addresses that rise by 4. `memSize` carries the code.
- R3: Each pointer has a step code, in control bits [4:3] for the source and [6:5] for the destination. After each unit, code 0 adds the unit length, code 2 subtracts it, and codes 1 and 3 hold the pointer.
- R4: Reload code 1 in control bits [8:7] selects circular mode. When the bytes moved since the last reload reach the wrap length (field select 3), both pointers return to their row start. The channel keeps running, does not use up its count and never signals done.
- R5: In circular mode a software start is discarded, and only the external request line can trigger the channel.
- R6: Reload code 2 selects two-dimensional mode. At the wrap length, the pitch (field select 4) is added to each row start, and each pointer is set to its new row start.
- R7: With `rrMode` low, the lowest-numbered requesting channel is served first.
- R8: With `rrMode` high, the channel served last has the lowest priority on the next grant.
- R9: Outside circular mode, each unit subtracts its length from the remaining count. The unit that brings the count to or below zero clears the enable (control bit 0) and raises that channel's `done` bit for exactly one cycle. After that, the channel makes no further transfers until it is re-enabled.
- R10: While `memReq` is high and `memAck` is low, `memReq`, `memAddr` and `memWrite` do not change.
- R11: After reset no request is issued, `done` is zero and every channel is disabled.
- R12: An external request or software start on a disabled channel causes no memory traffic.

Field selects: 0 source start, 1 destination start, 2 byte count, 3 wrap length, 4 pitch, 5 control. Writing a start address loads both the row start and the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rrMode | input | 1 | 1 selects round-robin arbitration, 0 selects fixed priority |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | 2 | Channel addressed by the write |
| cfgSel | input | 3 | Field addressed by the write |
| cfgData | input | 32 | Write data |
| swStart | input | 4 | Software start pulse, one bit per channel |
| extReq | input | 4 | External request level, one bit per channel |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | 1 for a write beat, 0 for a read beat |
| memAddr | output | 32 | Byte address of the beat |
| memSize | output | 2 | Unit size code of the active channel |
| memWdata | output | 32 | Write data from the channel buffer |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Completes the current beat |
| done | output | 4 | One-cycle completion pulse per channel |

## Verification
In two-dimensional mode, the last unit of a transfer can reach the wrap length and exhaust the count in the same update. The bench provokes this with a count that is an exact multiple of the wrap length: 24 bytes moved in 4-byte units with an 8-byte wrap. It then judges three things: the row advance must still be visible in the destination addresses, exactly one `done` pulse must appear, and a later software start must produce no traffic. Two channels can also request in the same cycle. The bench raises two external lines together and checks the order of the destination addresses under fixed and round-robin arbitration.

// File: rtl/dmaSeqPkg.sv
`timescale 1ns/1ps
package dmaSeqPkg;
  localparam int CH_W   = 2;
  localparam int BEAT_W = 3;

  typedef enum logic [1:0] {SZ_B1 = 2'd0, SZ_B2 = 2'd1, SZ_B4 = 2'd2, SZ_B32 = 2'd3} unitSize_e;
  typedef enum logic [1:0] {STEP_UP = 2'd0, STEP_KEEP = 2'd1, STEP_DOWN = 2'd2, STEP_ALT = 2'd3} stepMode_e;
  typedef enum logic [1:0] {RLD_OFF = 2'd0, RLD_CIRC = 2'd1, RLD_2D = 2'd2, RLD_ALT = 2'd3} reloadMode_e;
  typedef enum logic [2:0] {
    SEL_SRC = 3'd0, SEL_DST = 3'd1, SEL_COUNT = 3'd2,
    SEL_WRAP = 3'd3, SEL_PITCH = 3'd4, SEL_CTRL = 3'd5
  } cfgSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [CH_W-1:0]   chan;
    logic [BEAT_W-1:0] beat;
    logic              wrPhase;
    logic              rdStore;
    logic              unitEnd;
  } seqStb_t;
endpackage

// File: rtl/seqCtrl.sv
`timescale 1ns/1ps
module seqCtrl
  import dmaSeqPkg::*;
#(
  parameter int NCH   = 4,
  parameter int BEATS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  reqVec,
  input  logic            rrMode,
  input  logic [1:0]      actSize,
  input  logic            memAck,
  output seqStb_t         stb,
  output logic            memReq,
  output logic            memWrite,
  output logic            grantVld,
  output logic [CH_W-1:0] grantChan
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_UPDATE} state_e;

  state_e            state;
  logic [CH_W-1:0]   curChan, lastChan, cand;
  logic [BEAT_W-1:0] beat, lastBeat;

  // arbiter: fixed order from 0, or rotating start after lastChan
  always_comb begin
    grantVld  = 1'b0;
    grantChan = '0;
    cand      = '0;
    for (int k = 0; k < NCH; k++) begin
      cand = rrMode ? CH_W'((int'(lastChan) + 1 + k) % NCH) : CH_W'(k);
      if (!grantVld && state == ST_IDLE && reqVec[cand]) begin
        grantVld  = 1'b1;
        grantChan = cand;
      end
    end
  end

  assign lastBeat = (actSize == SZ_B32) ? BEAT_W'(BEATS - 1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      curChan  <= '0;
      lastChan <= CH_W'(NCH - 1);
      beat     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (grantVld) begin
          curChan  <= grantChan;
          lastChan <= grantChan;
          beat     <= '0;
          state    <= ST_READ;
        end
        ST_READ: if (memAck) begin
          if (beat == lastBeat) begin
            beat  <= '0;
            state <= ST_WRITE;
          end else beat <= beat + 1'b1;
        end
        ST_WRITE: if (memAck) begin
          if (beat == lastBeat) begin
            beat  <= '0;
            state <= ST_UPDATE;
          end else beat <= beat + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq      = (state == ST_READ) || (state == ST_WRITE);
  assign memWrite    = (state == ST_WRITE);
  assign stb.chan    = curChan;
  assign stb.beat    = beat;
  assign stb.wrPhase = (state == ST_WRITE);
  assign stb.rdStore = (state == ST_READ) && memAck;
  assign stb.unitEnd = (state == ST_UPDATE);
endmodule

// File: rtl/seqData.sv
`timescale 1ns/1ps
module seqData
  import dmaSeqPkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 32,
  parameter int UNIT_MAX = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWe,
  input  logic [CH_W-1:0] cfgChan,
  input  logic [2:0]      cfgSel,
  input  logic [AW-1:0]   cfgData,
  input  logic [NCH-1:0]  swStart,
  input  logic [NCH-1:0]  extReq,
  input  seqStb_t         stb,
  input  logic [DW-1:0]   memRdata,
  output logic [NCH-1:0]  reqVec,
  output logic [NCH-1:0]  enVec,
  output logic [1:0]      actSize,
  output logic [AW-1:0]   memAddr,
  output logic [1:0]      memSize,
  output logic [DW-1:0]   memWdata,
  output logic [NCH-1:0]  done
);
  localparam int BEAT_BYTES = DW / 8;
  localparam int BEATS      = UNIT_MAX / BEAT_BYTES;

  logic [AW-1:0]  srcCur [NCH], srcRow [NCH], dstCur [NCH], dstRow [NCH], pitch [NCH];
  logic [CW-1:0]  remain [NCH], wrapLen [NCH], wrapCnt [NCH];
  logic [1:0]     size [NCH], srcMode [NCH], dstMode [NCH], rldMode [NCH];
  logic [NCH-1:0] en, swPend;
  logic [DW-1:0]  dataBuf [NCH][BEATS];

  logic [CH_W-1:0] ch;
  logic [CW-1:0]   unitLen, wrapNext;
  logic [AW-1:0]   srcNext, dstNext, srcRowNext, dstRowNext;
  logic            wrapHit, lastUnit;

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a, input logic [1:0] m,
                                             input logic [CW-1:0] n);
    case (m)
      STEP_UP:   return a + AW'(n);
      STEP_DOWN: return a - AW'(n);
      default:   return a;
    endcase
  endfunction

  assign ch = stb.chan;

  // one shared update path for the active channel
  always_comb begin
    unitLen    = (size[ch] == SZ_B32) ? CW'(UNIT_MAX) : (CW'(1) << size[ch]);
    wrapNext   = wrapCnt[ch] + unitLen;
    wrapHit    = (rldMode[ch] == RLD_CIRC || rldMode[ch] == RLD_2D) && (wrapNext >= wrapLen[ch]);
    lastUnit   = (rldMode[ch] != RLD_CIRC) && (remain[ch] <= unitLen);
    srcRowNext = (rldMode[ch] == RLD_2D) ? srcRow[ch] + pitch[ch] : srcRow[ch];
    dstRowNext = (rldMode[ch] == RLD_2D) ? dstRow[ch] + pitch[ch] : dstRow[ch];
    srcNext    = wrapHit ? srcRowNext : stepAddr(srcCur[ch], srcMode[ch], unitLen);
    dstNext    = wrapHit ? dstRowNext : stepAddr(dstCur[ch], dstMode[ch], unitLen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= '0;
      swPend <= '0;
      done   <= '0;
      for (int c = 0; c < NCH; c++) begin
        srcCur[c] <= '0; srcRow[c] <= '0; dstCur[c] <= '0; dstRow[c] <= '0;
        pitch[c] <= '0; remain[c] <= '0; wrapLen[c] <= '0; wrapCnt[c] <= '0;
        size[c] <= '0; srcMode[c] <= '0; dstMode[c] <= '0; rldMode[c] <= '0;
      end
    end else begin
      done <= '0;
      for (int c = 0; c < NCH; c++) begin
        if (swStart[c] && en[c] && rldMode[c] != RLD_CIRC) swPend[c] <= 1'b1;
        if (cfgWe && cfgChan == CH_W'(c)) begin
          case (cfgSel)
            SEL_SRC:   begin srcRow[c] <= cfgData; srcCur[c] <= cfgData; end
            SEL_DST:   begin dstRow[c] <= cfgData; dstCur[c] <= cfgData; end
            SEL_COUNT: remain[c] <= CW'(cfgData);
            SEL_WRAP:  begin wrapLen[c] <= CW'(cfgData); wrapCnt[c] <= '0; end
            SEL_PITCH: pitch[c] <= cfgData;
            SEL_CTRL: begin
              en[c]      <= cfgData[0];
              size[c]    <= cfgData[2:1];
              srcMode[c] <= cfgData[4:3];
              dstMode[c] <= cfgData[6:5];
              rldMode[c] <= cfgData[8:7];
              wrapCnt[c] <= '0;
              if (!cfgData[0]) swPend[c] <= 1'b0;
            end
            default: ;
          endcase
        end else if (stb.unitEnd && ch == CH_W'(c)) begin
          srcCur[c] <= srcNext;
          dstCur[c] <= dstNext;
          if (wrapHit) begin
            wrapCnt[c] <= '0;
            srcRow[c]  <= srcRowNext;
            dstRow[c]  <= dstRowNext;
          end else begin
            wrapCnt[c] <= wrapNext;
          end
          if (rldMode[c] != RLD_CIRC) remain[c] <= lastUnit ? '0 : remain[c] - unitLen;
          if (lastUnit) begin
            en[c]     <= 1'b0;
            swPend[c] <= 1'b0;
            done[c]   <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.rdStore) dataBuf[ch][stb.beat] <= memRdata;
  end

  assign reqVec   = en & (extReq | swPend);
  assign enVec    = en;
  assign actSize  = size[ch];
  assign memSize  = size[ch];
  assign memAddr  = (stb.wrPhase ? dstCur[ch] : srcCur[ch]) +
                    ((size[ch] == SZ_B32) ? AW'(stb.beat) * AW'(BEAT_BYTES) : '0);
  assign memWdata = dataBuf[ch][stb.beat];
endmodule

// File: rtl/dmaAddrSequencer.sv
`timescale 1ns/1ps
module dmaAddrSequencer
  import dmaSeqPkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 32,
  parameter int UNIT_MAX = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rrMode,
  input  logic            cfgWe,
  input  logic [CH_W-1:0] cfgChan,
  input  logic [2:0]      cfgSel,
  input  logic [AW-1:0]   cfgData,
  input  logic [NCH-1:0]  swStart,
  input  logic [NCH-1:0]  extReq,
  output logic            memReq,
  output logic            memWrite,
  output logic [AW-1:0]   memAddr,
  output logic [1:0]      memSize,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata,
  input  logic            memAck,
  output logic [NCH-1:0]  done
);
  localparam int BEATS = UNIT_MAX / (DW / 8);

  seqStb_t         stb;
  logic [NCH-1:0]  reqVec, enVec;
  logic [1:0]      actSize;
  logic            grantVld;
  logic [CH_W-1:0] grantChan;

  seqCtrl #(.NCH(NCH), .BEATS(BEATS)) uCtrl (
    .clk(clk), .rst(rst), .reqVec(reqVec), .rrMode(rrMode), .actSize(actSize),
    .memAck(memAck), .stb(stb), .memReq(memReq), .memWrite(memWrite),
    .grantVld(grantVld), .grantChan(grantChan)
  );

  seqData #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .UNIT_MAX(UNIT_MAX)) uData (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgSel(cfgSel),
    .cfgData(cfgData), .swStart(swStart), .extReq(extReq), .stb(stb),
    .memRdata(memRdata), .reqVec(reqVec), .enVec(enVec), .actSize(actSize),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .done(done)
  );
endmodule

// File: rtl/dmaSeqChecker.sv
`timescale 1ns/1ps
module dmaSeqChecker
  import dmaSeqPkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rrMode,
  input logic            memReq,
  input logic            memAck,
  input logic            memWrite,
  input logic [AW-1:0]   memAddr,
  input logic [NCH-1:0]  done,
  input logic [NCH-1:0]  reqVec,
  input logic [NCH-1:0]  enVec,
  input logic            grantVld,
  input logic [CH_W-1:0] grantChan
);
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  a_r1_read_first: assert property (@(posedge clk) disable iff (rst)
    $rose(memReq) |-> !memWrite);

  a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));

  a_r9_done_disables: assert property (@(posedge clk) disable iff (rst)
    (done & enVec) == '0);

  a_r12_grant_enabled: assert property (@(posedge clk) disable iff (rst)
    grantVld |-> (enVec[grantChan] && reqVec[grantChan]));

  a_r7_fixed_lowest: assert property (@(posedge clk) disable iff (rst)
    (grantVld && !rrMode) |-> ((reqVec & ((NCH'(1) << grantChan) - NCH'(1))) == '0));
endmodule

bind dmaAddrSequencer dmaSeqChecker #(.NCH(NCH), .AW(AW)) uChk (
  .clk(clk), .rst(rst), .rrMode(rrMode), .memReq(memReq), .memAck(memAck),
  .memWrite(memWrite), .memAddr(memAddr), .done(done), .reqVec(reqVec),
  .enVec(enVec), .grantVld(grantVld), .grantChan(grantChan)
);

// File: tb/tb_dmaAddrSequencer.sv
`timescale 1ns/1ps
module tb_dmaAddrSequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rrMode = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgChan = '0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic [3:0]  swStart = '0;
  logic [3:0]  extReq = '0;
  logic        memReq, memWrite, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memSize;
  logic [3:0]  done;

  int nChk = 0, nFail = 0;
  logic [31:0] wAddr [512];
  logic [31:0] wData [512];
  int wN = 0;
  int doneCnt [4] = '{0, 0, 0, 0};
  bit wdFired = 0;

  always #2.5 clk = ~clk;

  dmaAddrSequencer dut (
    .clk(clk), .rst(rst), .rrMode(rrMode), .cfgWe(cfgWe), .cfgChan(cfgChan),
    .cfgSel(cfgSel), .cfgData(cfgData), .swStart(swStart), .extReq(extReq),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .done(done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // memory model: acknowledges each beat one cycle after the request
  assign memRdata = pat(memAddr);
  always @(posedge clk) begin
    if (rst) memAck <= 1'b0;
    else     memAck <= memReq && !memAck;
  end

  always @(posedge clk) begin
    if (!rst && memReq && memAck && memWrite && wN < 512) begin
      wAddr[wN] <= memAddr;
      wData[wN] <= memWdata;
      wN        <= wN + 1;
    end
    for (int c = 0; c < 4; c++) if (!rst && done[c]) doneCnt[c] <= doneCnt[c] + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgChan = 2'(ch); cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseSw(input int ch);
    @(negedge clk);
    swStart = 4'(1 << ch);
    @(negedge clk);
    swStart = '0;
  endtask

  task automatic waitDone(input int ch, input int prev);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (doneCnt[ch] != prev) break;
    end
  endtask

  typedef struct packed {
    logic [1:0]  sz, sm, dm;
    logic [31:0] src, dst, cnt;
    logic [7:0]  nw;
    logic [31:0] lDst, lSrc;
  } vec_t;

  // size / src step / dst step / src / dst / count / writes / last dst / last src
  localparam vec_t VECS [5] = '{
    '{2'd2, 2'd0, 2'd0, 32'h100, 32'h800, 32'd16, 8'd4,  32'h80C, 32'h10C},
    '{2'd0, 2'd0, 2'd2, 32'h200, 32'h900, 32'd3,  8'd3,  32'h8FE, 32'h202},
    '{2'd1, 2'd1, 2'd0, 32'h300, 32'hA00, 32'd6,  8'd3,  32'hA04, 32'h300},
    '{2'd3, 2'd0, 2'd0, 32'h400, 32'hB00, 32'd64, 8'd16, 32'hB3C, 32'h43C},
    '{2'd2, 2'd2, 2'd1, 32'h500, 32'hC00, 32'd8,  8'd2,  32'hC00, 32'h4FC}
  };

  task automatic runAll();
    int s, d0, d3;
    // reset state (R11)
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 memReq after reset", 32'(memReq), 32'd0);
    chk("R11 done after reset", 32'(done), 32'd0);

    // requests on disabled channels are ignored (R12)
    s = wN;
    extReq = 4'hF;
    pulseSw(2);
    repeat (20) @(negedge clk);
    chk("R12 no traffic while disabled", 32'(wN - s), 32'd0);
    chk("R12 memReq low while disabled", 32'(memReq), 32'd0);
    extReq = '0;

    // vector table: sizes (R2), step modes (R3), data pass-through (R1), completion (R9)
    for (int i = 0; i < 5; i++) begin
      int ch = i % 4;
      int pd;
      cfg(ch, 3'd0, VECS[i].src);
      cfg(ch, 3'd1, VECS[i].dst);
      cfg(ch, 3'd2, VECS[i].cnt);
      cfg(ch, 3'd5, 32'(1) | (32'(VECS[i].sz) << 1) | (32'(VECS[i].sm) << 3) | (32'(VECS[i].dm) << 5));
      s  = wN;
      pd = doneCnt[ch];
      pulseSw(ch);
      waitDone(ch, pd);
      repeat (3) @(negedge clk);
      chk($sformatf("R2 write count vec%0d", i), 32'(wN - s), 32'(VECS[i].nw));
      chk($sformatf("R3 last dst vec%0d", i), wAddr[s + VECS[i].nw - 1], VECS[i].lDst);
      chk($sformatf("R1 last data vec%0d", i), wData[s + VECS[i].nw - 1], pat(VECS[i].lSrc));
      chk($sformatf("R9 done pulses vec%0d", i), 32'(doneCnt[ch] - pd), 32'd1);
      if (VECS[i].sz == 2'd3) begin
        chk("R2 beat 7 address", wAddr[s + 7], VECS[i].dst + 32'd28);
        chk("R1 beat 7 data", wData[s + 7], pat(VECS[i].src + 32'd28));
      end
      s = wN;
      pulseSw(ch);
      repeat (20) @(negedge clk);
      chk($sformatf("R9 no restart after done vec%0d", i), 32'(wN - s), 32'd0);
    end

    // circular mode on channel 1 (R4, R5)
    cfg(1, 3'd0, 32'h1000);
    cfg(1, 3'd1, 32'h2000);
    cfg(1, 3'd2, 32'd4);
    cfg(1, 3'd3, 32'd8);
    cfg(1, 3'd5, 32'h85);
    s  = wN;
    d0 = doneCnt[1];
    pulseSw(1);
    repeat (20) @(negedge clk);
    chk("R5 software start ignored in circular", 32'(wN - s), 32'd0);
    extReq = 4'b0010;
    for (int i = 0; i < 400 && wN < s + 5; i++) @(negedge clk);
    extReq = '0;
    repeat (40) @(negedge clk);
    chk("R4 circ addr 0", wAddr[s],     32'h2000);
    chk("R4 circ addr 1", wAddr[s + 1], 32'h2004);
    chk("R4 circ addr 2 reload", wAddr[s + 2], 32'h2000);
    chk("R4 circ addr 3", wAddr[s + 3], 32'h2004);
    chk("R4 circ data after reload", wData[s + 2], pat(32'h1000));
    chk("R4 no done in circular", 32'(doneCnt[1] - d0), 32'd0);
    cfg(1, 3'd5, 32'h0);

    // two-dimensional mode on channel 2; last unit both wraps and ends (R6, R9)
    cfg(2, 3'd0, 32'h4000);
    cfg(2, 3'd1, 32'h3000);
    cfg(2, 3'd2, 32'd24);
    cfg(2, 3'd3, 32'd8);
    cfg(2, 3'd4, 32'h100);
    cfg(2, 3'd5, 32'h105);
    s  = wN;
    d0 = doneCnt[2];
    pulseSw(2);
    waitDone(2, d0);
    repeat (3) @(negedge clk);
    chk("R6 2D write count", 32'(wN - s), 32'd6);
    chk("R6 2D addr 1", wAddr[s + 1], 32'h3004);
    chk("R6 2D addr 2 next row", wAddr[s + 2], 32'h3100);
    chk("R6 2D addr 4 third row", wAddr[s + 4], 32'h3200);
    chk("R6 2D addr 5", wAddr[s + 5], 32'h3204);
    chk("R6 2D src row data", wData[s + 5], pat(32'h4204));
    chk("R9 2D single done", 32'(doneCnt[2] - d0), 32'd1);
    s = wN;
    pulseSw(2);
    repeat (20) @(negedge clk);
    chk("R9 2D no restart", 32'(wN - s), 32'd0);

    // fixed priority then round-robin with channels 0 and 3 (R7, R8)
    for (int m = 0; m < 2; m++) begin
      cfg(0, 3'd0, 32'h7000);
      cfg(0, 3'd1, 32'h5000);
      cfg(0, 3'd2, 32'd8);
      cfg(0, 3'd5, 32'h5);
      cfg(3, 3'd0, 32'h7100);
      cfg(3, 3'd1, 32'h6000);
      cfg(3, 3'd2, 32'd8);
      cfg(3, 3'd5, 32'h5);
      rrMode = (m == 1);
      s  = wN;
      d0 = doneCnt[0];
      d3 = doneCnt[3];
      @(negedge clk);
      extReq = 4'b1001;
      repeat (100) @(negedge clk);
      extReq = '0;
      repeat (5) @(negedge clk);
      chk(m == 0 ? "R7 write count" : "R8 write count", 32'(wN - s), 32'd4);
      chk(m == 0 ? "R7 done ch0" : "R8 done ch0", 32'(doneCnt[0] - d0), 32'd1);
      chk(m == 0 ? "R7 done ch3" : "R8 done ch3", 32'(doneCnt[3] - d3), 32'd1);
      if (m == 0) begin
        chk("R7 order 0", wAddr[s],     32'h5000);
        chk("R7 order 1", wAddr[s + 1], 32'h5004);
        chk("R7 order 2", wAddr[s + 2], 32'h6000);
        chk("R7 order 3", wAddr[s + 3], 32'h6004);
      end else begin
        chk("R8 order 0", wAddr[s],     32'h5000);
        chk("R8 order 1", wAddr[s + 1], 32'h6000);
        chk("R8 order 2", wAddr[s + 2], 32'h5004);
        chk("R8 order 3", wAddr[s + 3], 32'h6004);
        chk("R2 size code on port", 32'(memSize), 32'd2);
      end
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        wdFired = 1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule